// File: doc/BRIEF.md
# Touch ADC Serial Conversion Sequencer

This block is the device-side serial front end of a successive-approximation touch-screen converter. It runs on the serial clock, samples the command input on rising edges and updates the result and busy outputs on falling edges. Chip select is active low and frames all activity. The block ignores the command input until it samples a 1, which it takes as a start bit. It then collects seven more bits, opens a three-cycle acquisition window and signals the hold/convert phase. It pulses the busy flag for one cycle and then shifts the conversion result out, most significant bit first.

The analog comparator is modelled by a result word that the block samples at conversion start. In 8-bit mode only the top eight bits of that word are sent. A following command may overlap the current shift-out. A new start bit is accepted 15 clocks after the previous one in 12-bit mode and 11 clocks after it in 8-bit mode. This supports 24-, 16- and 15-clock framings.

Top module: `touch_adc_seq`

## Requirements
- R1: While the block is waiting for a command, a 0 on the command input has no effect: no acquisition, no strobe and no output activity.
- R2: If the start bit is sampled at rising edge s, edges s+1..s+7 deliver, in order, a 3-bit channel code (MSB first), the resolution bit (1 = 8-bit), the reference-mode bit and a 2-bit power code (MSB first). All fields appear on their outputs, together with a one-cycle strobe, after edge s+7.
- R3: The acquisition output is high after edges s+4, s+5 and s+6 only, exactly three cycles, and it falls when the strobe rises.
- R4: The busy output is high for exactly one cycle, from the falling edge after rising edge s+7. The result data follows on the next falling edge.
- R5: The result word is sampled at edge s+8 and sent in straight binary, MSB first. Bit i appears on the falling edge after rising edge s+8+i. 12 bits are sent when the resolution bit is 0 and the top 8 bits when it is 1. At all other times the data output is low.
- R6: The hold/convert output is high for 12 cycles (or 8 in 8-bit mode), starting after edge s+7.
- R7: A new start bit is accepted no earlier than edge s+15 (12-bit) or s+11 (8-bit). A 1 before that edge is ignored.
- R8: A command decoded while a previous result is still being shifted out does not alter the data output.
- R9: While chip select is high the output-drive enable is low at once. One rising edge with chip select high clears the sequence, so the next command is decoded from a clean state.
- R10: After reset the busy, data, acquisition, strobe and hold outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| din_i | input | 1 | Serial command input |
| conv_data_i | input | RES_W | Comparator result word, sampled at conversion start |
| dout_o | output | 1 | Serial result output |
| busy_o | output | 1 | Busy flag |
| drv_en_o | output | 1 | Drive enable for data and busy pads (0 = high impedance) |
| acq_o | output | 1 | Acquisition window |
| conv_o | output | 1 | Hold/convert phase |
| cfg_stb_o | output | 1 | One-cycle strobe: decoded fields valid |
| chan_o | output | 3 | Channel select code |
| res8_o | output | 1 | 8-bit resolution selected |
| ref_se_o | output | 1 | Single-ended reference selected |
| pd_o | output | 2 | Power-down code |

## Verification
In the 15-clock framing, the control byte of command n+1 is sampled on the same edges that shift out the final bits of command n. In 8-bit back-to-back runs, the acquisition of the next command starts while the previous result is still on the data output. The bench provokes both cases by scheduling starts exactly at the earliest legal edge. It also places stray 1s on the command input before the rearm point. A schedule-based model predicts every output, edge by edge, and compares it on every clock. Any corruption of the data stream or any early start is therefore caught at the cycle where it occurs.

// File: rtl/touch_adc_seq_pkg.sv
package touch_adc_seq_pkg;
  localparam int unsigned CTL_W = 7;

  typedef struct packed {
    logic [2:0] chan;
    logic       res8;
    logic       ref_se;
    logic [1:0] pd;
  } cmd_cfg_t;
endpackage

// File: rtl/tas_cmd_decode.sv
module tas_cmd_decode
  import touch_adc_seq_pkg::*;
#(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned SHORT_W = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     din_i,
  output cmd_cfg_t cfg_o,
  output logic     stb_o,
  output logic     acq_o
);
  localparam int unsigned GAP_L = RES_W + 3;
  localparam int unsigned GAP_S = SHORT_W + 3;
  localparam int unsigned CNT_W = $clog2(GAP_L + 1);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(GAP_L - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(GAP_S - 1);

  logic             armed_q, active_q, acq_q, stb_q;
  logic [2:0]       bit_q;
  logic [CTL_W-2:0] sr_q;
  logic [CNT_W-1:0] gap_q;
  cmd_cfg_t         cfg_q;
  logic             start;

  assign start = armed_q & din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1; active_q <= 1'b0; acq_q <= 1'b0; stb_q <= 1'b0;
      bit_q <= '0; sr_q <= '0; gap_q <= '0; cfg_q <= '0;
    end else if (cs_ni) begin
      armed_q <= 1'b1; active_q <= 1'b0; acq_q <= 1'b0; stb_q <= 1'b0;
      bit_q <= '0; sr_q <= '0; gap_q <= '0; cfg_q <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start) begin
        armed_q  <= 1'b0;
        active_q <= 1'b1;
        bit_q    <= 3'd1;
        gap_q    <= CNT_W'(1);
      end else if (!armed_q) begin
        gap_q <= gap_q + 1'b1;
        // rearm so that the start bit is sampled exactly GAP edges later
        if (gap_q == (cfg_q.res8 ? LAST_S : LAST_L)) armed_q <= 1'b1;
      end
      if (active_q) begin
        sr_q  <= {sr_q[CTL_W-3:0], din_i};
        bit_q <= bit_q + 1'b1;
        if (bit_q == 3'd4) acq_q <= 1'b1;
        if (bit_q == 3'd7) begin
          active_q <= 1'b0;
          acq_q    <= 1'b0;
          stb_q    <= 1'b1;
          cfg_q    <= cmd_cfg_t'({sr_q, din_i});
        end
      end
    end
  end

  assign cfg_o = cfg_q;
  assign stb_o = stb_q;
  assign acq_o = acq_q;

  p_din_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (armed_q && !din_i) |=> (!active_q && !acq_q));
  p_acq_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    $rose(acq_q) |=> acq_q ##1 acq_q ##1 !acq_q);
  p_stb_after_acq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    stb_q |-> $past(acq_q));
  p_cs_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (armed_q && !active_q && !stb_q));
endmodule

// File: rtl/tas_result_shift.sv
module tas_result_shift #(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned SHORT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             stb_i,
  input  logic             res8_i,
  input  logic [RES_W-1:0] data_i,
  output logic             dout_nxt_o,
  output logic             busy_nxt_o,
  output logic             conv_o
);
  localparam int unsigned LW = $clog2(RES_W + 1);
  localparam logic [LW-1:0] N_L = LW'(RES_W);
  localparam logic [LW-1:0] N_S = LW'(SHORT_W);

  logic [RES_W-1:0] sr_q;
  logic [LW-1:0]    left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; left_q <= '0;
    end else if (cs_ni) begin
      sr_q <= '0; left_q <= '0;
    end else if (stb_i) begin
      // 8-bit mode uses the top bits of the same word
      sr_q   <= data_i;
      left_q <= res8_i ? N_S : N_L;
    end else if (left_q != '0) begin
      sr_q   <= sr_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign dout_nxt_o = (left_q != '0) & sr_q[RES_W-1];
  assign busy_nxt_o = stb_i;
  assign conv_o     = stb_i | (left_q >= LW'(2));

  p_load_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    stb_i |=> (left_q == (res8_i ? N_S : N_L)));
  p_no_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    stb_i |-> (left_q == '0));
endmodule

// File: rtl/touch_adc_seq.sv
module touch_adc_seq
  import touch_adc_seq_pkg::*;
#(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned SHORT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             din_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             dout_o,
  output logic             busy_o,
  output logic             drv_en_o,
  output logic             acq_o,
  output logic             conv_o,
  output logic             cfg_stb_o,
  output logic [2:0]       chan_o,
  output logic             res8_o,
  output logic             ref_se_o,
  output logic [1:0]       pd_o
);
  cmd_cfg_t cfg;
  logic     stb, dout_nxt, busy_nxt;
  logic     dout_q, busy_q;

  tas_cmd_decode #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_dec (
    .clk_i (clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .din_i(din_i),
    .cfg_o (cfg),   .stb_o (stb),    .acq_o(acq_o)
  );

  tas_result_shift #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_shift (
    .clk_i     (clk_i),    .rst_ni    (rst_ni),   .cs_ni (cs_ni),
    .stb_i     (stb),      .res8_i    (cfg.res8), .data_i(conv_data_i),
    .dout_nxt_o(dout_nxt), .busy_nxt_o(busy_nxt), .conv_o(conv_o)
  );

  // pad-facing outputs change on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 1'b0; busy_q <= 1'b0;
    end else if (cs_ni) begin
      dout_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      dout_q <= dout_nxt; busy_q <= busy_nxt;
    end
  end

  assign dout_o    = dout_q;
  assign busy_o    = busy_q;
  assign drv_en_o  = ~cs_ni;
  assign cfg_stb_o = stb;
  assign chan_o    = cfg.chan;
  assign res8_o    = cfg.res8;
  assign ref_se_o  = cfg.ref_se;
  assign pd_o      = cfg.pd;

  p_busy_pulse_r4: assert property (@(negedge clk_i) disable iff (!rst_ni || cs_ni)
    busy_q |=> !busy_q);
  p_busy_quiet_r5: assert property (@(negedge clk_i) disable iff (!rst_ni || cs_ni)
    busy_q |-> !dout_q);
  p_drv_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !drv_en_o);
endmodule

// File: tb/touch_adc_seq_test.sv
module touch_adc_seq_test;
  localparam int MAXE = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        din = 1'b0;
  logic [11:0] cdata = '0;
  logic dout, busy, drv_en, acq, conv, stb, res8, ref_se;
  logic [2:0] chan;
  logic [1:0] pd;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic        din_a [MAXE];
  logic [11:0] dat_a [MAXE];
  logic        e_acq [MAXE], e_conv [MAXE], e_stb [MAXE], e_busy [MAXE], e_dout [MAXE];
  logic [6:0]  e_cfg [MAXE];

  always #10 clk = ~clk;

  touch_adc_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .din_i(din), .conv_data_i(cdata),
    .dout_o(dout), .busy_o(busy), .drv_en_o(drv_en), .acq_o(acq), .conv_o(conv),
    .cfg_stb_o(stb), .chan_o(chan), .res8_o(res8), .ref_se_o(ref_se), .pd_o(pd)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_sched();
    for (int i = 0; i < MAXE; i++) begin
      din_a[i] = 0; dat_a[i] = '0; e_acq[i] = 0; e_conv[i] = 0;
      e_stb[i] = 0; e_busy[i] = 0; e_dout[i] = 0; e_cfg[i] = '0;
    end
  endtask

  // command with start bit at rising edge s
  task automatic add_cmd(int s, logic [6:0] ctl, logic [11:0] d);
    int n;
    n = ctl[3] ? 8 : 12;
    din_a[s] = 1;
    for (int j = 0; j < 7; j++) din_a[s+1+j] = ctl[6-j];
    for (int j = 4; j < 7; j++) e_acq[s+j] = 1;
    e_stb[s+7] = 1; e_cfg[s+7] = ctl; e_busy[s+7] = 1;
    for (int j = 0; j < n; j++) e_conv[s+7+j] = 1;
    dat_a[s+8] = d;
    for (int i = 0; i < n; i++) e_dout[s+8+i] = d[11-i];
  endtask

  task automatic run(int len);
    @(negedge clk);
    cs_ni = 1'b1; din = 1'b0;
    #1 chk("R9 drive off", drv_en, 0);
    @(negedge clk);
    @(negedge clk);
    cs_ni = 1'b0; din = din_a[0]; cdata = dat_a[0];
    for (int e = 0; e < len; e++) begin
      @(posedge clk);
      #5;
      chk("R3 acq", acq, e_acq[e]);
      chk("R6 conv", conv, e_conv[e]);
      chk("R2 strobe", stb, e_stb[e]);
      if (e_stb[e]) chk("R2 fields", {chan, res8, ref_se, pd}, e_cfg[e]);
      @(negedge clk);
      #5;
      chk("R4 busy", busy, e_busy[e]);
      chk("R5 R8 dout", dout, e_dout[e]);
      chk("R9 drive on", drv_en, 1);
      din = (e + 1 < len) ? din_a[e+1] : 1'b0;
      cdata = (e + 1 < len) ? dat_a[e+1] : '0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 dout", dout, 0);
    chk("R10 acq", acq, 0);
    chk("R10 strobe", stb, 0);
    chk("R10 conv", conv, 0);
    rst_ni = 1'b1;

    // 24-clock framing with idle zeros first (R1)
    clear_sched();
    add_cmd(3,  7'b001_0_0_00, 12'hA5C);
    add_cmd(27, 7'b101_1_1_01, 12'h3F1);
    add_cmd(51, 7'b110_0_0_11, 12'h801);
    run(76);

    // 16-clock framing
    clear_sched();
    add_cmd(0,  7'b011_0_1_10, 12'hFFF);
    add_cmd(16, 7'b100_0_0_00, 12'h001);
    add_cmd(32, 7'b010_0_1_01, 12'h6B3);
    add_cmd(48, 7'b111_1_0_00, 12'hC47);
    add_cmd(64, 7'b000_1_1_11, 12'h5A0);
    run(84);

    // 15-clock / 11-clock overlap, earliest legal starts (R7, R8)
    clear_sched();
    add_cmd(0,  7'b001_0_0_01, 12'h9D2);
    add_cmd(15, 7'b101_0_1_00, 12'h2E7);
    add_cmd(30, 7'b011_0_0_11, 12'hF0F);
    add_cmd(45, 7'b100_1_1_00, 12'h86C);
    add_cmd(56, 7'b010_1_0_10, 12'h3B9);
    add_cmd(67, 7'b110_1_1_01, 12'hE15);
    run(90);

    // stray ones before the rearm point are ignored (R7)
    clear_sched();
    add_cmd(0,  7'b001_0_1_00, 12'h4C3);
    din_a[10] = 1; din_a[14] = 1;
    add_cmd(24, 7'b011_1_0_01, 12'hB7E);
    din_a[33] = 1;
    add_cmd(48, 7'b111_0_0_10, 12'h1D8);
    run(70);

    // abort mid shift-out, then mid control byte (R9)
    clear_sched();
    add_cmd(2, 7'b101_0_0_00, 12'hFFF);
    run(14);
    clear_sched();
    add_cmd(1, 7'b111_1_1_11, 12'hFFF);
    run(5);
    clear_sched();
    add_cmd(0, 7'b010_0_1_01, 12'h5C6);
    run(22);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule